// File: doc/BRIEF.md
# Modulo Address Pointer Update Unit

This unit produces the post-access value of an address pointer used by X or Y bus data transfers in a DSP datapath. It can make that pointer step through a circular buffer. The access can leave the pointer unchanged, advance it by one word (two bytes), or add an index register to it. When circular addressing is enabled for the bus the access uses, the unit compares the pointer held before the access with an end offset. On a match it reloads a start offset instead of advancing. A single 32-bit modulo register holds both offsets.

The updated pointer is available combinationally, so the caller can use it in the same cycle. A writeback register captures that value on every cycle in which an access strobe is high. A one-cycle wrap pulse marks each access in which the start offset replaced the advanced value. Only the low 16 bits take part in the wrap, so a circular buffer is at most 64 KB. Bit 0 of every address operand is disregarded.

Top module: `mod_ptr_update`

## Requirements
- R1: `modReg` holds the end offset in bits 31:16 and the start offset in bits 15:0. With `modReg` = 0x70047000, the end offset is 0x7004 and the start offset is 0x7000.
- R2: The wrap enable is taken from `enX` when `busSelY` is 0 and from `enY` when `busSelY` is 1. The enable of the bus that is not selected has no effect.
- R3: When `addrMode` is 2'b01 (increment) and no wrap occurs, `nextPtr` equals `curPtr + 2` with bit 0 cleared.
- R4: A wrap occurs when all of the following hold: `addrMode` is 2'b01 or 2'b10, the selected enable is 1, and `curPtr[15:1]` equals `modReg[31:17]`. On a wrap, `nextPtr` is `{curPtr[31:16], modReg[15:1], 1'b0}`.
- R5: When `addrMode` is 2'b00 (no update) or 2'b11 (reserved), `nextPtr` equals `curPtr` with bit 0 cleared. No wrap occurs, even when the pointer equals the end offset.
- R6: When `addrMode` is 2'b10 (index add) and no wrap occurs, `nextPtr` equals `curPtr + idxVal` with bit 0 cleared. A sum that steps past the end offset does not wrap.
- R7: Bit 0 of `nextPtr` is always 0. Bit 0 of `curPtr` and of both offsets is left out of the end-offset comparison.
- R8: When the selected enable is 0, the update is plain 32-bit addition. Its carry propagates into bits 31:16, for example 0x0000FFFE + 2 = 0x00010000.
- R9: If `accessValid` is high at a clock edge, `ptrReg` takes `nextPtr` and `wrapPulse` takes the wrap decision. If `accessValid` is low, `ptrReg` holds and `wrapPulse` is 0.
- R10: While `rstN` is low, `ptrReg` and `wrapPulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| accessValid | input | 1 | Access strobe that loads the writeback register |
| curPtr | input | 32 | Pointer value before the access |
| addrMode | input | 2 | 00 no update, 01 increment by 2, 10 add index, 11 reserved (no update) |
| idxVal | input | 32 | Index register value |
| busSelY | input | 1 | 0 selects the X bus, 1 selects the Y bus |
| modReg | input | 32 | End offset in bits 31:16, start offset in bits 15:0 |
| enX | input | 1 | Circular addressing enable for the X bus |
| enY | input | 1 | Circular addressing enable for the Y bus |
| nextPtr | output | 32 | Updated pointer (combinational) |
| ptrReg | output | 32 | Registered pointer writeback |
| wrapPulse | output | 1 | High for one cycle after an access that wrapped |

## Verification
The assertions assume that every input holds a known value whenever reset is released. They also assume that the inputs stay stable around the clock edge, so the wrap decision and the sum seen at the edge match the values that were checked combinationally. The bench changes all inputs only at the falling clock edge and gives each one a defined value. It then sweeps pointers across both sides of the end offset, including odd pointers, under every mode, both buses, all enable combinations, two index values and two upper-half bases. A final part toggles the access strobe to cover the hold behaviour.

// File: rtl/mau_pkg.sv
package mau_pkg;
  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_INC  = 2'b01,
    MODE_IDX  = 2'b10,
    MODE_RSV  = 2'b11
  } addrMode_e;

  typedef struct packed {
    logic useAdd;   // advance the pointer
    logic useIdx;   // addend is the index register rather than the step
    logic doWrap;   // substitute the start offset
    logic load;     // capture into writeback register
  } mauStrobe_t;
endpackage

// File: rtl/mau_ctrl.sv
module mau_ctrl
  import mau_pkg::*;
#(
  parameter int OFFW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            accessValid,
  input  addrMode_e       mode,
  input  logic [OFFW-1:0] ptrLow,
  input  logic [OFFW-1:0] endOff,
  input  logic            busSelY,
  input  logic            enX,
  input  logic            enY,
  output mauStrobe_t      strb
);
  logic enSel;
  logic endHit;
  logic stepping;

  always_comb begin
    enSel    = busSelY ? enY : enX;
    endHit   = (ptrLow[OFFW-1:1] == endOff[OFFW-1:1]);
    stepping = (mode == MODE_INC) || (mode == MODE_IDX);
    strb.useAdd = stepping;
    strb.useIdx = (mode == MODE_IDX);
    strb.doWrap = stepping && enSel && endHit;
    strb.load   = accessValid;
  end

  // R5: a non-stepping access never requests a wrap or an add
  p_noupdate_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == MODE_NONE) || (mode == MODE_RSV)) |-> (!strb.doWrap && !strb.useAdd));

  // R2: with both enables low no wrap can be requested
  p_disabled_nowrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!enX && !enY) |-> !strb.doWrap);
endmodule

// File: rtl/mau_datapath.sv
module mau_datapath
  import mau_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int OFFW  = 16,
  parameter int STEP  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  mauStrobe_t       strb,
  input  logic [WIDTH-1:0] curPtr,
  input  logic [WIDTH-1:0] idxVal,
  input  logic [OFFW-1:0]  startOff,
  output logic [WIDTH-1:0] nextPtr,
  output logic [WIDTH-1:0] ptrReg,
  output logic             wrapPulse
);
  localparam int HIW = WIDTH - OFFW;

  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] raw;

  always_comb begin
    addend = strb.useIdx ? idxVal : WIDTH'(STEP);
    sum    = curPtr + addend;
    if (strb.doWrap)
      raw = {curPtr[WIDTH-1:OFFW], startOff};
    else if (strb.useAdd)
      raw = sum;
    else
      raw = curPtr;
    nextPtr = {raw[WIDTH-1:1], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrReg    <= '0;
      wrapPulse <= 1'b0;
    end else begin
      if (strb.load) ptrReg <= nextPtr;
      wrapPulse <= strb.load && strb.doWrap;
    end
  end

  // R4: a wrap keeps the upper half and loads the start offset
  p_wrap_value_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.doWrap |-> (nextPtr[WIDTH-1:OFFW] == curPtr[WIDTH-1:OFFW]) &&
                    (nextPtr[OFFW-1:1] == startOff[OFFW-1:1]));

  // R9: writeback holds without an access strobe
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(ptrReg));

  // R9: writeback captures the updated pointer
  p_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (ptrReg == $past(nextPtr)));

  // R9: wrap pulse only follows an access
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |-> $past(strb.load));

  // R7: registered pointer is always even
  p_even_r7: assert property (@(posedge clk) disable iff (!rstN)
    ptrReg[0] == 1'b0);

  logic unusedHi;
  assign unusedHi = ^HIW;
endmodule

// File: rtl/mod_ptr_update.sv
module mod_ptr_update
  import mau_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int OFFW  = 16,
  parameter int STEP  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accessValid,
  input  logic [WIDTH-1:0] curPtr,
  input  logic [1:0]       addrMode,
  input  logic [WIDTH-1:0] idxVal,
  input  logic             busSelY,
  input  logic [2*OFFW-1:0] modReg,
  input  logic             enX,
  input  logic             enY,
  output logic [WIDTH-1:0] nextPtr,
  output logic [WIDTH-1:0] ptrReg,
  output logic             wrapPulse
);
  mauStrobe_t strb;
  logic [OFFW-1:0] endOff;
  logic [OFFW-1:0] startOff;

  assign endOff   = modReg[2*OFFW-1:OFFW];
  assign startOff = modReg[OFFW-1:0];

  mau_ctrl #(.OFFW(OFFW)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .accessValid (accessValid),
    .mode        (addrMode_e'(addrMode)),
    .ptrLow      (curPtr[OFFW-1:0]),
    .endOff      (endOff),
    .busSelY     (busSelY),
    .enX         (enX),
    .enY         (enY),
    .strb        (strb)
  );

  mau_datapath #(.WIDTH(WIDTH), .OFFW(OFFW), .STEP(STEP)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .curPtr    (curPtr),
    .idxVal    (idxVal),
    .startOff  (startOff),
    .nextPtr   (nextPtr),
    .ptrReg    (ptrReg),
    .wrapPulse (wrapPulse)
  );
endmodule

// File: tb/mod_ptr_update_bench.sv
module mod_ptr_update_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accessValid = 1'b0;
  logic [31:0] curPtr = '0;
  logic [1:0]  addrMode = '0;
  logic [31:0] idxVal = '0;
  logic        busSelY = 1'b0;
  logic [31:0] modReg = '0;
  logic        enX = 1'b0;
  logic        enY = 1'b0;
  logic [31:0] nextPtr;
  logic [31:0] ptrReg;
  logic        wrapPulse;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mod_ptr_update u_mod_ptr_update (
    .clk(clk), .rstN(rstN), .accessValid(accessValid), .curPtr(curPtr),
    .addrMode(addrMode), .idxVal(idxVal), .busSelY(busSelY), .modReg(modReg),
    .enX(enX), .enY(enY), .nextPtr(nextPtr), .ptrReg(ptrReg), .wrapPulse(wrapPulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected value straight from the requirements
  function automatic logic [32:0] model(input logic [31:0] p, input logic [1:0] m,
      input logic [31:0] ix, input logic sy, input logic [31:0] mr,
      input logic ex, input logic ey);
    logic en;
    logic hit;
    logic [31:0] r;
    en  = sy ? ey : ex;
    hit = (p[15:1] == mr[31:17]);
    if ((m == 2'b01 || m == 2'b10) && en && hit)
      return {1'b1, p[31:16], mr[15:1], 1'b0};
    if (m == 2'b01)      r = p + 32'd2;
    else if (m == 2'b10) r = p + ix;
    else                 r = p;
    return {1'b0, r[31:1], 1'b0};
  endfunction

  function automatic string tagOf(input logic [1:0] m, input logic w, input logic en);
    if (m == 2'b00 || m == 2'b11) return "R5";
    if (w) return "R4";
    if (!en) return "R8";
    if (m == 2'b10) return "R6";
    return "R3";
  endfunction

  task automatic access(input logic [31:0] p, input logic [1:0] m, input logic [31:0] ix,
      input logic sy, input logic [31:0] mr, input logic ex, input logic ey, input string tag);
    logic [32:0] e;
    string t;
    @(negedge clk);
    curPtr = p; addrMode = m; idxVal = ix; busSelY = sy; modReg = mr;
    enX = ex; enY = ey; accessValid = 1'b1;
    e = model(p, m, ix, sy, mr, ex, ey);
    t = (tag == "") ? tagOf(m, e[32], sy ? ey : ex) : tag;
    #1;
    check(t, nextPtr, e[31:0]);
    @(negedge clk);
    accessValid = 1'b0;
    check({t, "/R9 reg"}, ptrReg, e[31:0]);
    check({t, "/R9 pulse"}, {31'b0, wrapPulse}, {31'b0, e[32]});
  endtask

  initial begin
    #5_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] bases [2];
    logic [31:0] mods [2];
    logic [31:0] held;
    bases[0] = 32'hA500_0000; bases[1] = 32'h0001_0000;
    mods[0]  = 32'h7004_7000; mods[1]  = 32'h0108_0100;
    repeat (3) @(negedge clk);
    check("R10 ptr", ptrReg, 32'h0);
    check("R10 pulse", {31'b0, wrapPulse}, 32'h0);
    rstN = 1'b1;

    // R1 / R4: word walk around the 0x7000..0x7004 ring
    access(32'hA500_7000, 2'b01, 0, 0, 32'h7004_7000, 1, 0, "R1 step");
    access(32'hA500_7002, 2'b01, 0, 0, 32'h7004_7000, 1, 0, "R1 step");
    access(32'hA500_7004, 2'b01, 0, 0, 32'h7004_7000, 1, 0, "R1 wrap");
    // R2: only the selected bus enable matters
    access(32'hA500_7004, 2'b01, 0, 1, 32'h7004_7000, 1, 0, "R2 Y off");
    access(32'hA500_7004, 2'b01, 0, 1, 32'h7004_7000, 0, 1, "R2 Y on");
    // R6: index steps over the end offset
    access(32'hA500_7002, 2'b10, 32'h6, 0, 32'h7004_7000, 1, 0, "R6 skip");
    // R7: odd pointer still matches the end offset
    access(32'hA500_7005, 2'b01, 0, 0, 32'h7004_7000, 1, 0, "R7 odd");
    access(32'hA500_7003, 2'b00, 0, 0, 32'h7004_7000, 1, 0, "R7 even");
    // R8: carry crosses into the upper half when disabled
    access(32'h0000_FFFE, 2'b01, 0, 0, 32'h7004_7000, 0, 0, "R8 carry");

    // R9: hold when the strobe is low
    held = ptrReg;
    @(negedge clk);
    curPtr = 32'h1234_5678; addrMode = 2'b01; accessValid = 1'b0;
    @(negedge clk);
    check("R9 hold", ptrReg, held);
    check("R9 no pulse", {31'b0, wrapPulse}, 32'h0);

    // sweep
    for (int b = 0; b < 2; b++)
      for (int md = 0; md < 2; md++)
        for (int off = -4; off <= 10; off++)
          for (int m = 0; m < 4; m++)
            for (int sy = 0; sy < 2; sy++)
              for (int en = 0; en < 4; en++)
                for (int ix = 0; ix < 2; ix++)
                  access(bases[b] + {16'h0, mods[md][15:0]} + 32'(off), 2'(m),
                         ix ? 32'h6 : 32'h2, 1'(sy), mods[md], en[0], en[1], "");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule